// File: doc/BRIEF.md
# Dual-Candidate Correlation Trigger Condition with Missing-Energy Cut

Each bunch crossing, this block receives four calorimeter candidates of a single kind, such as isolated electron/photon objects, together with a missing transverse energy value. It decides whether the crossing contains two different candidates, where one meets a first selection and the other meets a second selection. Each selection is a minimum transverse energy plus an inclusive eta-index window, and either selection can also demand the isolation flag.

The pair result is registered as the condition bit. A second registered output, the algorithm bit, is that condition ANDed with an inclusive threshold test on the missing-energy value. The selection thresholds, windows and the isolation demand are static inputs that software loads between runs. Ordering the candidates and aligning them in time happen upstream of this block.

Top module: `dual_obj_met_cond`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both `cond_o` and `algo_o` read 0.
- R2: Each candidate is a 16-bit word laid out as {iso[15], phi[14:10], eta[9:6], et[5:0]}. Candidate k occupies `cand_i[16k+15:16k]`. A candidate meets a selection when et >= that selection's threshold and lo <= eta <= hi, with both window bounds inclusive.
- R3: `cond_o` is 1 only when two different candidate slots are involved. A single candidate that meets both selections, while no other candidate meets either one, gives 0.
- R4: When `iso_req` is 1, a candidate whose bit 15 is 0 meets neither selection. When `iso_req` is 0, bit 15 is ignored.
- R5: A candidate with et equal to 0 is empty and meets neither selection, even when a threshold is 0.
- R6: `algo_o` equals `cond_o` AND (`met_i` >= `met_thr`). The missing-energy comparison is inclusive.
- R7: The outputs show the inputs sampled at the previous rising clock edge, which is one cycle of latency. Changing the inputs between edges does not change the outputs.
- R8: All 12 ordered pairs (i, j) with i != j are evaluated. Selection 1 on slot i together with selection 2 on slot j sets `cond_o` for every such pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_i | input | 64 | Four packed candidates |
| met_i | input | 10 | Missing transverse energy |
| thr1 | input | 6 | Selection 1 ET threshold |
| eta_lo1 | input | 4 | Selection 1 eta lower bound |
| eta_hi1 | input | 4 | Selection 1 eta upper bound |
| thr2 | input | 6 | Selection 2 ET threshold |
| eta_lo2 | input | 4 | Selection 2 eta lower bound |
| eta_hi2 | input | 4 | Selection 2 eta upper bound |
| iso_req | input | 1 | Demand isolation flag in both selections |
| met_thr | input | 10 | Missing-energy threshold |
| cond_o | output | 1 | Registered two-candidate condition |
| algo_o | output | 1 | Registered condition AND missing-energy cut |

## Verification
Both outputs are due exactly one rising edge after the inputs that produce them. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, one edge later.

In the latency scenario, the bench also reads the outputs in the middle of the cycle, right after changing inputs. At that point they must still show the previous crossing's result.

For every scenario, the expected values come from a bench model of the requirements, which is evaluated when the stimulus is applied.

// File: rtl/dual_obj_met_cond.sv
module dual_obj_met_cond #(
  parameter int NCAND = 4,
  parameter int ETW   = 6,
  parameter int ETAW  = 4,
  parameter int PHIW  = 5,
  parameter int METW  = 10,
  localparam int CW   = ETW + ETAW + PHIW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCAND*CW-1:0]   cand_i,
  input  logic [METW-1:0]       met_i,
  input  logic [ETW-1:0]        thr1,
  input  logic [ETAW-1:0]       eta_lo1,
  input  logic [ETAW-1:0]       eta_hi1,
  input  logic [ETW-1:0]        thr2,
  input  logic [ETAW-1:0]       eta_lo2,
  input  logic [ETAW-1:0]       eta_hi2,
  input  logic                  iso_req,
  input  logic [METW-1:0]       met_thr,
  output logic                  cond_o,
  output logic                  algo_o
);

  logic [NCAND-1:0] sel1, sel2, live, isof;
  logic             pair_hit, met_ok;

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    logic [ETW-1:0]  et;
    logic [ETAW-1:0] eta;
    assign et      = cand_i[g*CW +: ETW];
    assign eta     = cand_i[g*CW + ETW +: ETAW];
    assign isof[g] = cand_i[g*CW + CW - 1];
    assign live[g] = |et;
    assign sel1[g] = live[g] && (isof[g] || !iso_req) && (et >= thr1)
                     && (eta >= eta_lo1) && (eta <= eta_hi1);
    assign sel2[g] = live[g] && (isof[g] || !iso_req) && (et >= thr2)
                     && (eta >= eta_lo2) && (eta <= eta_hi2);
  end

  always_comb begin
    pair_hit = 1'b0;
    for (int i = 0; i < NCAND; i++)
      for (int j = 0; j < NCAND; j++)
        if (i != j) pair_hit = pair_hit | (sel1[i] & sel2[j]);
  end

  assign met_ok = (met_i >= met_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_o <= 1'b0;
      algo_o <= 1'b0;
    end else begin
      cond_o <= pair_hit;
      algo_o <= pair_hit & met_ok;
    end
  end

  p_algo_needs_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    algo_o |-> cond_o);

  p_met_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (met_i < met_thr) |=> !algo_o);

  p_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(live) <= 1) |=> !cond_o);

  p_iso_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_req && (isof == '0)) |=> !cond_o);

  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> (!cond_o && !algo_o));

endmodule

// File: tb/sim_dual_obj_met_cond.sv
module sim_dual_obj_met_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cand_i = '0;
  logic [9:0]  met_i = '0, met_thr = '0;
  logic [5:0]  thr1 = '0, thr2 = '0;
  logic [3:0]  eta_lo1 = '0, eta_hi1 = '0, eta_lo2 = '0, eta_hi2 = '0;
  logic        iso_req = 1'b0;
  logic        cond_o, algo_o;
  int checks = 0, failures = 0;
  logic exp_c, exp_a;

  always #5 clk = ~clk;

  dual_obj_met_cond u0 (.clk, .rst_n, .cand_i, .met_i, .thr1, .eta_lo1, .eta_hi1,
    .thr2, .eta_lo2, .eta_hi2, .iso_req, .met_thr, .cond_o, .algo_o);

  function automatic logic [15:0] mk(int et, int eta, int phi, bit iso);
    return {iso, phi[4:0], eta[3:0], et[5:0]};
  endfunction

  function automatic bit meets(logic [15:0] c, int s);
    int et = c[5:0], eta = c[9:6];
    int t = (s == 1) ? thr1 : thr2;
    int lo = (s == 1) ? eta_lo1 : eta_lo2;
    int hi = (s == 1) ? eta_hi1 : eta_hi2;
    if (et == 0) return 0;
    if (iso_req && !c[15]) return 0;
    return (et >= t) && (eta >= lo) && (eta <= hi);
  endfunction

  function automatic void model();
    exp_c = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (i != j && meets(cand_i[16*i +: 16], 1) && meets(cand_i[16*j +: 16], 2)) exp_c = 1;
    exp_a = exp_c && (met_i >= met_thr);
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic apply(string req);
    model();
    @(negedge clk);
    chk(req, cond_o, exp_c, "cond_o");
    chk(req, algo_o, exp_a, "algo_o");
  endtask

  task automatic setsel(int t1, int l1, int h1, int t2, int l2, int h2);
    thr1 = t1[5:0]; eta_lo1 = l1[3:0]; eta_hi1 = h1[3:0];
    thr2 = t2[5:0]; eta_lo2 = l2[3:0]; eta_hi2 = h2[3:0];
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", cond_o, 1'b0, "cond_o in reset");
    chk("R1", algo_o, 1'b0, "algo_o in reset");
    setsel(0, 0, 15, 0, 0, 15);
    cand_i = {4{mk(10, 3, 1, 1)}};
    rst_n = 1'b1;
    chk("R1", cond_o, 1'b0, "cond_o after release");
  endtask

  task automatic t_basic();
    setsel(20, 2, 8, 10, 0, 15);
    met_thr = 100; met_i = 200;
    cand_i = {mk(0,0,0,0), mk(0,0,0,0), mk(12,1,3,0), mk(25,5,7,0)};
    apply("R2");
    chk("R2", cond_o, 1'b1, "basic pair");
  endtask

  task automatic t_edges();
    setsel(20, 2, 8, 10, 2, 8);
    cand_i = {32'h0, mk(10,8,0,0), mk(20,2,0,0)};
    apply("R2");
    chk("R2", cond_o, 1'b1, "inclusive bounds");
    cand_i = {32'h0, mk(10,8,0,0), mk(19,2,0,0)};
    apply("R2");
    chk("R2", cond_o, 1'b0, "et one below thr1");
    cand_i = {32'h0, mk(10,9,0,0), mk(20,2,0,0)};
    apply("R2");
    chk("R2", cond_o, 1'b0, "eta above hi2");
    cand_i = {32'h0, mk(10,8,0,0), mk(20,1,0,0)};
    apply("R2");
  endtask

  task automatic t_distinct();
    setsel(5, 0, 15, 5, 0, 15);
    cand_i = {48'h0, mk(30,4,0,0)};
    apply("R3");
    chk("R3", cond_o, 1'b0, "single candidate meets both");
    cand_i = {32'h0, mk(30,4,0,0), mk(30,4,0,0)};
    apply("R3");
    chk("R3", cond_o, 1'b1, "two identical candidates");
  endtask

  task automatic t_iso();
    setsel(5, 0, 15, 5, 0, 15);
    iso_req = 1;
    cand_i = {32'h0, mk(30,4,0,1), mk(30,4,0,0)};
    apply("R4");
    chk("R4", cond_o, 1'b0, "one not isolated");
    cand_i = {32'h0, mk(30,4,0,1), mk(30,4,0,1)};
    apply("R4");
    iso_req = 0;
    cand_i = {32'h0, mk(30,4,0,0), mk(30,4,0,0)};
    apply("R4");
    chk("R4", cond_o, 1'b1, "iso ignored when not required");
  endtask

  task automatic t_empty();
    setsel(0, 0, 15, 0, 0, 15);
    met_thr = 0;
    cand_i = {mk(0,4,3,1), mk(0,5,3,1), mk(0,6,3,1), mk(0,7,3,1)};
    apply("R5");
    chk("R5", cond_o, 1'b0, "all empty thr zero");
    cand_i = {mk(0,4,3,1), mk(1,5,3,1), mk(0,6,3,1), mk(0,7,3,1)};
    apply("R5");
  endtask

  task automatic t_met();
    setsel(5, 0, 15, 5, 0, 15);
    cand_i = {32'h0, mk(30,4,0,0), mk(30,4,0,0)};
    met_thr = 300; met_i = 300;
    apply("R6");
    chk("R6", algo_o, 1'b1, "met equal thr");
    met_i = 299;
    apply("R6");
    chk("R6", algo_o, 1'b0, "met below thr");
    cand_i = '0; met_i = 1023;
    apply("R6");
    chk("R6", algo_o, 1'b0, "met high no pair");
  endtask

  task automatic t_pairs();
    setsel(40, 0, 15, 5, 0, 3);
    met_thr = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        if (i == j) continue;
        cand_i = '0;
        cand_i[16*i +: 16] = mk(45, 10, i, 0);
        cand_i[16*j +: 16] = mk(8, 2, j, 0);
        apply("R8");
        chk("R8", cond_o, 1'b1, $sformatf("pair %0d,%0d", i, j));
      end
  endtask

  task automatic t_latency();
    setsel(5, 0, 15, 5, 0, 15);
    met_thr = 0;
    cand_i = {32'h0, mk(30,4,0,0), mk(30,4,0,0)};
    apply("R7");
    cand_i = '0;
    #2;
    chk("R7", cond_o, 1'b1, "holds before edge");
    chk("R7", algo_o, 1'b1, "holds before edge");
    apply("R7");
    chk("R7", cond_o, 1'b0, "updates after edge");
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_1234;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cand_i = {lf, ~lf ^ {lf[15:0], lf[31:16]}};
      setsel(lf[5:0], lf[9:6] & 4'h7, lf[13:10] | 4'h8, lf[19:14], lf[23:20] & 4'h3, lf[27:24] | 4'hC);
      iso_req = lf[28];
      met_i = lf[9:0]; met_thr = lf[19:10];
      apply(n[0] ? "R8" : "R2");
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_edges();
    t_distinct();
    t_iso();
    t_empty();
    t_met();
    t_pairs();
    t_latency();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule